// File: doc/BRIEF.md
# Termination Resistor Calibration Sequencer

This block drives an on-chip termination resistor calibration through a bit-addressed configuration space. It does not touch that space directly. It issues one command at a time to a serial configuration engine. Each command is a write or a read of a field of 1 or 4 bits at a bit address. The sequencer waits for the engine's acknowledge before it moves on.

A start pulse launches a fixed program. The program first returns the override, start and enable controls to zero. It then powers the calibration circuit and lets it settle for a programmable number of cycles before it triggers the measurement. It polls the ready flag until the flag is set. It then reads the 4-bit measured code and copies it into the trim field. Last, it turns the calibration circuit off and hands the trim over to the override setting.

A bounded poll count keeps a dead calibration circuit from hanging the sequencer. Instead it reports a timeout.

Top module: `rescal_seq`

## Requirements
- R1: After a start pulse, the first three commands are 1-bit writes of 0 to bit addresses 0x43 (override), 0x41 (measure start) and 0x40 (enable), in that order.
- R2: The next two commands are a 1-bit write of 1 to 0x40, followed by a 1-bit write of 1 to 0x41.
- R3: The sequencer then issues 1-bit reads of address 0x42. It repeats them while `cmd_rdata_i[0]` returns 0 and goes on once it returns 1.
- R4: Next comes a 4-bit read at 0x49, where `cmd_rdata_i[i]` is the bit at 0x49+i. A 4-bit write at 0x44 follows, carrying the same value, with `cmd_wdata_o[i]` going to 0x44+i. `cmd_len_o` gives the field width in bits, 1 or 4.
- R5: The program closes with 1-bit writes of 0 to 0x41, then 0 to 0x40, then 1 to 0x43, and issues no further command.
- R6: `busy_o` is high from the cycle after an accepted start until the final write is acknowledged. In the next cycle `done_o` is high for exactly one cycle and `busy_o` is low.
- R7: Between the acknowledge of the 0x40=1 write and the request of the 0x41=1 write, `cmd_valid_o` stays low for exactly SETTLE_CYC+1 cycles.
- R8: Suppose MAX_POLLS reads of 0x42 in a row return 0. The sequencer then issues no further command and drops `busy_o`. It raises `timeout_o` and gives no `done_o`. `timeout_o` holds until the next accepted start. A 1 returned on read number MAX_POLLS still counts as success.
- R9: A start pulse while `busy_o` is high has no effect on the command stream.
- R10: Only one command is outstanding at a time. `cmd_valid_o` and all command fields hold steady until `cmd_done_i`. `cmd_valid_o` is low in the cycle after an acknowledge. Outside the settle wait, the next request follows after exactly one low cycle.
- R11: After reset, `busy_o`, `done_o`, `timeout_o` and `cmd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the calibration program (ignored while busy) |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| timeout_o | output | 1 | Ready flag never seen within MAX_POLLS reads |
| cmd_valid_o | output | 1 | Command request to the configuration engine |
| cmd_write_o | output | 1 | 1 = write, 0 = read |
| cmd_addr_o | output | 8 | Bit address of the field's lowest bit |
| cmd_len_o | output | 3 | Field width in bits |
| cmd_wdata_o | output | 4 | Write data, bit i goes to address+i |
| cmd_done_i | input | 1 | Engine acknowledge, one cycle |
| cmd_rdata_i | input | 4 | Read data, valid with cmd_done_i |

## Verification
The assertions check the handshake discipline on every cycle. Fields hold while a request waits, the request drops after an acknowledge, and the bus stays silent during the settle wait. They also check the one-cycle done pulse, the sticky timeout and the rule that a start during a run never ends busy early. Only the bench scenarios can show the exact ordering and content of the whole command stream. The same goes for the copy of a random measured code into the trim field, the exact settle gap, and the boundary between success on the last allowed poll and a timeout.

// File: rtl/rescal_pkg.sv
package rescal_pkg;
  localparam int ADDR_W = 8;
  localparam int CODE_W = 4;
  localparam int LEN_W  = 3;
  localparam int STEP_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_SETTLE} seq_state_e;

  localparam logic [STEP_W-1:0] STP_CLR_OVR = 4'd0;
  localparam logic [STEP_W-1:0] STP_CLR_GO  = 4'd1;
  localparam logic [STEP_W-1:0] STP_CLR_EN  = 4'd2;
  localparam logic [STEP_W-1:0] STP_SET_EN  = 4'd3;
  localparam logic [STEP_W-1:0] STP_SET_GO  = 4'd4;
  localparam logic [STEP_W-1:0] STP_POLL    = 4'd5;
  localparam logic [STEP_W-1:0] STP_RD_CODE = 4'd6;
  localparam logic [STEP_W-1:0] STP_WR_TRIM = 4'd7;
  localparam logic [STEP_W-1:0] STP_END_GO  = 4'd8;
  localparam logic [STEP_W-1:0] STP_END_EN  = 4'd9;
  localparam logic [STEP_W-1:0] STP_SET_OVR = 4'd10;

  localparam logic [ADDR_W-1:0] A_EN   = 8'h40;
  localparam logic [ADDR_W-1:0] A_GO   = 8'h41;
  localparam logic [ADDR_W-1:0] A_RDY  = 8'h42;
  localparam logic [ADDR_W-1:0] A_OVR  = 8'h43;
  localparam logic [ADDR_W-1:0] A_TRIM = 8'h44;
  localparam logic [ADDR_W-1:0] A_CODE = 8'h49;
endpackage

// File: rtl/rescal_step_table.sv
module rescal_step_table
  import rescal_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [CODE_W-1:0] wdata_o
);
  localparam logic [LEN_W-1:0] LEN_BIT  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_CODE = LEN_W'(CODE_W);

  always_comb begin
    write_o = 1'b1;
    addr_o  = A_OVR;
    len_o   = LEN_BIT;
    wdata_o = '0;
    unique case (step_i)
      STP_CLR_OVR: addr_o = A_OVR;
      STP_CLR_GO:  addr_o = A_GO;
      STP_CLR_EN:  addr_o = A_EN;
      STP_SET_EN:  begin addr_o = A_EN; wdata_o = CODE_W'(1); end
      STP_SET_GO:  begin addr_o = A_GO; wdata_o = CODE_W'(1); end
      STP_POLL:    begin addr_o = A_RDY; write_o = 1'b0; end
      STP_RD_CODE: begin addr_o = A_CODE; write_o = 1'b0; len_o = LEN_CODE; end
      STP_WR_TRIM: begin addr_o = A_TRIM; len_o = LEN_CODE; wdata_o = code_i; end
      STP_END_GO:  addr_o = A_GO;
      STP_END_EN:  addr_o = A_EN;
      STP_SET_OVR: begin addr_o = A_OVR; wdata_o = CODE_W'(1); end
      default:     ;
    endcase
  end
endmodule

// File: rtl/rescal_timer.sv
module rescal_timer #(
  parameter int CYC = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= CW'(CYC);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rescal_poll_ctr.sv
module rescal_poll_ctr #(
  parameter int MAX = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic miss_i,
  output logic last_o
);
  localparam int CW = (MAX > 1) ? $clog2(MAX) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (miss_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX - 1));
endmodule

// File: rtl/rescal_seq.sv
module rescal_seq
  import rescal_pkg::*;
#(
  parameter int SETTLE_CYC = 125000,
  parameter int MAX_POLLS  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic [CODE_W-1:0] cmd_wdata_o,
  input  logic              cmd_done_i,
  input  logic [CODE_W-1:0] cmd_rdata_i
);
  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [CODE_W-1:0] code_q;
  logic              valid_q, busy_q, done_q, timeout_q;
  logic              ack, settle_go, poll_last, poll_miss, poll_clr, settle_done;

  assign ack       = (state_q == ST_CMD) && valid_q && cmd_done_i;
  assign settle_go = ack && (step_q == STP_SET_EN);
  assign poll_miss = ack && (step_q == STP_POLL) && !cmd_rdata_i[0] && !poll_last;
  assign poll_clr  = (state_q == ST_IDLE) && start_i;

  rescal_step_table u_table (
    .step_i (step_q),
    .code_i (code_q),
    .write_o(cmd_write_o),
    .addr_o (cmd_addr_o),
    .len_o  (cmd_len_o),
    .wdata_o(cmd_wdata_o)
  );

  rescal_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (settle_go),
    .expired_o(settle_done)
  );

  rescal_poll_ctr #(.MAX(MAX_POLLS)) u_poll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (poll_clr),
    .miss_i(poll_miss),
    .last_o(poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= STP_CLR_OVR;
      code_q    <= '0;
      valid_q   <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_CMD;
          step_q    <= STP_CLR_OVR;
          busy_q    <= 1'b1;
          timeout_q <= 1'b0;
        end
        ST_CMD: begin
          if (!valid_q) begin
            valid_q <= 1'b1;
          end else if (cmd_done_i) begin
            valid_q <= 1'b0;
            unique case (step_q)
              STP_SET_EN: begin
                step_q  <= step_q + 1'b1;
                state_q <= ST_SETTLE;
              end
              STP_POLL: begin
                if (cmd_rdata_i[0]) step_q <= step_q + 1'b1;
                else if (poll_last) begin
                  timeout_q <= 1'b1;
                  busy_q    <= 1'b0;
                  state_q   <= ST_IDLE;
                end
              end
              STP_RD_CODE: begin
                code_q <= cmd_rdata_i;
                step_q <= step_q + 1'b1;
              end
              STP_SET_OVR: begin
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
              default: step_q <= step_q + 1'b1;
            endcase
          end
        end
        ST_SETTLE: if (settle_done) begin
          valid_q <= 1'b1;
          state_q <= ST_CMD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = valid_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign timeout_o   = timeout_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R10
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_write_o)
      && $stable(cmd_len_o) && $stable(cmd_wdata_o));
  // R10
  cmd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_done_i |=> !cmd_valid_o);
  // R10
  cmd_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);
  // R7
  settle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SETTLE |-> !cmd_valid_o);
  // R8
  timeout_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !start_i |=> timeout_o);
  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !cmd_done_i |=> busy_o);
endmodule

// File: tb/rescal_seq_bench.sv
`timescale 1ns/1ps
module rescal_seq_bench;
  localparam int SETTLE = 12;
  localparam int POLLS  = 5;

  logic       clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, cmd_done_i = 1'b0;
  logic [3:0] cmd_rdata_i = '0;
  logic       busy_o, done_o, timeout_o, cmd_valid_o, cmd_write_o;
  logic [7:0] cmd_addr_o;
  logic [2:0] cmd_len_o;
  logic [3:0] cmd_wdata_o;

  always #4 clk_i = ~clk_i;

  rescal_seq #(.SETTLE_CYC(SETTLE), .MAX_POLLS(POLLS)) u_rescal_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o), .cmd_addr_o(cmd_addr_o),
    .cmd_len_o(cmd_len_o), .cmd_wdata_o(cmd_wdata_o),
    .cmd_done_i(cmd_done_i), .cmd_rdata_i(cmd_rdata_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // engine and analog model
  logic [127:0] mem;
  int  poll_zero, poll_cnt, tr_n, gap;
  bit  unstable, lowbad;
  bit  tr_w[64];
  int  tr_a[64], tr_l[64], tr_d[64], tr_gap[64];

  initial begin
    gap = 0; tr_n = 0; unstable = 0; lowbad = 0; mem = '0; poll_cnt = 0; poll_zero = 0;
    forever begin
      @(negedge clk_i);
      if (cmd_valid_o) begin
        int lat;
        int k;
        k = (tr_n < 64) ? tr_n : 63;
        tr_w[k] = cmd_write_o; tr_a[k] = int'(cmd_addr_o);
        tr_l[k] = int'(cmd_len_o); tr_d[k] = int'(cmd_wdata_o); tr_gap[k] = gap;
        tr_n++;
        gap = 0;
        lat = int'($urandom % 3);
        repeat (lat) begin
          @(negedge clk_i);
          if (!cmd_valid_o || cmd_write_o != tr_w[k] || int'(cmd_addr_o) != tr_a[k] ||
              int'(cmd_len_o) != tr_l[k] || int'(cmd_wdata_o) != tr_d[k]) unstable = 1;
        end
        cmd_rdata_i = '0;
        if (cmd_write_o) begin
          for (int i = 0; i < int'(cmd_len_o); i++) mem[int'(cmd_addr_o) + i] = cmd_wdata_o[i];
        end else if (cmd_addr_o == 8'h42) begin
          cmd_rdata_i[0] = (poll_cnt >= poll_zero) && mem[8'h40] && mem[8'h41];
          poll_cnt++;
        end else begin
          for (int i = 0; i < int'(cmd_len_o); i++) cmd_rdata_i[i] = mem[int'(cmd_addr_o) + i];
        end
        cmd_done_i = 1'b1;
        @(negedge clk_i);
        cmd_done_i = 1'b0;
        if (cmd_valid_o) lowbad = 1;
        gap = 1;
      end else begin
        gap++;
      end
    end
  end

  // expected command stream
  bit ex_w[64];
  int ex_a[64], ex_l[64], ex_d[64];
  int ex_n, ex_np;

  task automatic add_ex(bit w, int a, int l, int d);
    ex_w[ex_n] = w; ex_a[ex_n] = a; ex_l[ex_n] = l; ex_d[ex_n] = d; ex_n++;
  endtask

  task automatic build_ex(int code, int pz, bit to);
    ex_n = 0;
    add_ex(1, 'h43, 1, 0); add_ex(1, 'h41, 1, 0); add_ex(1, 'h40, 1, 0);
    add_ex(1, 'h40, 1, 1); add_ex(1, 'h41, 1, 1);
    ex_np = to ? POLLS : pz + 1;
    for (int i = 0; i < ex_np; i++) add_ex(0, 'h42, 1, 0);
    if (!to) begin
      add_ex(0, 'h49, 4, 0); add_ex(1, 'h44, 4, code);
      add_ex(1, 'h41, 1, 0); add_ex(1, 'h40, 1, 0); add_ex(1, 'h43, 1, 1);
    end
  endtask

  function automatic string tag_of(int k);
    if (k < 3) return "R1";
    if (k < 5) return "R2";
    if (k < 5 + ex_np) return "R3";
    if (k < 7 + ex_np) return "R4";
    return "R5";
  endfunction

  task automatic run(int code, int pz, bit restart_mid);
    bit to;
    int cyc, dn;
    bit busy_ok, fin, ok;
    to = (pz >= POLLS);
    mem = '0;
    for (int i = 0; i < 4; i++) mem['h49 + i] = code[i];
    poll_cnt = 0; poll_zero = pz; tr_n = 0; unstable = 0; lowbad = 0;
    build_ex(code, pz, to);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o == 1'b1, "R6", "busy after start", busy_o, 1);
    chk(timeout_o == 1'b0, "R8", "timeout cleared by start", timeout_o, 0);
    cyc = 0; dn = 0; busy_ok = 1; fin = 0;
    while (!fin && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
      start_i = restart_mid && (cyc == 8);
      if (done_o) begin dn++; if (busy_o) busy_ok = 0; fin = 1; end
      else if (!busy_o) fin = 1;
    end
    start_i = 1'b0;
    repeat (4) begin
      @(negedge clk_i);
      if (done_o) dn++;
    end
    chk(dn == (to ? 0 : 1), "R6", "done pulse count", dn, to ? 0 : 1);
    chk(busy_ok && !busy_o, "R6", "busy low at/after done", busy_o, 0);
    chk(timeout_o == to, "R8", "timeout flag", timeout_o, to);
    chk(tr_n == ex_n, restart_mid ? "R9" : (to ? "R8" : "R3"), "command count", tr_n, ex_n);
    for (int k = 0; k < ex_n && k < tr_n; k++) begin
      ok = tr_w[k] == ex_w[k] && tr_a[k] == ex_a[k] && tr_l[k] == ex_l[k] &&
           (!ex_w[k] || tr_d[k] == ex_d[k]);
      chk(ok, tag_of(k), $sformatf("command %0d {w,addr,len,data}", k),
          {tr_w[k], tr_a[k][7:0], tr_l[k][3:0], tr_d[k][3:0]},
          {ex_w[k], ex_a[k][7:0], ex_l[k][3:0], ex_d[k][3:0]});
    end
    chk(mem['h44 +: 4] == (to ? 4'h0 : code[3:0]), "R4", "trim field", mem['h44 +: 4],
        to ? 0 : code);
    if (!to)
      chk({mem['h43], mem['h41], mem['h40]} == 3'b100, "R5", "final {ovr,go,en}",
          {mem['h43], mem['h41], mem['h40]}, 3'b100);
    if (tr_n > 4) chk(tr_gap[4] == SETTLE + 1, "R7", "settle gap", tr_gap[4], SETTLE + 1);
    for (int k = 1; k < tr_n && k < 64; k++)
      if (k != 4) chk(tr_gap[k] == 1, "R10", $sformatf("gap before command %0d", k), tr_gap[k], 1);
    chk(!unstable && !lowbad, "R10", "request held and released", {unstable, lowbad}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c41));
    #1;
    chk(!busy_o && !done_o && !timeout_o && !cmd_valid_o, "R11", "outputs in reset",
        {busy_o, done_o, timeout_o, cmd_valid_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !timeout_o && !cmd_valid_o, "R11", "outputs after reset",
        {busy_o, done_o, timeout_o, cmd_valid_o}, 0);
    run('hA, 0, 0);
    run('h0, POLLS - 1, 0);   // success on last allowed poll
    run('hF, POLLS, 0);       // timeout at the boundary
    run('h3, 1, 1);           // start while busy
    run('h9, POLLS + 4, 0);
    for (int r = 0; r < 8; r++) run(int'($urandom % 16), int'($urandom % 7), r[0]);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule